// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This block sits between a processor-side port that issues byte, halfword and word accesses and a peripheral register space in which every register has one fixed native width of 1, 2 or 4 bytes. A parameter map gives the native width of each 4-byte group of the register space. The adapter turns every upstream access into downstream accesses that match the register's native width. Downstream data is right-justified at that width and byte order is big-endian: the byte with the lower address is the more significant one.

When an access is wider than the target register, the adapter issues a run of native-width pieces at rising addresses, most significant piece first. When an access is narrower, a read fetches the whole register and extracts the addressed part. A narrower write fetches the register, merges the new bytes into it and writes it back. Illegal accesses are answered with an error and reach nothing downstream.

Top module: `mwa_adapter`

## Requirements
- R1: Only the low 10 bits of the upstream address form the offset; higher bits are ignored. An offset with bit 9 set (0x200 and above) returns an error and issues no downstream access.
- R2: The map holds a 2-bit code per group, selected by offset bits [8:2]: 1 = byte, 2 = halfword, 3 = word, 0 = unmapped. An access to an unmapped group returns an error and issues no downstream access.
- R3: An access whose size equals the native width becomes exactly one downstream access at the same offset, with the same size and data.
- R4: A read narrower than the register issues one native read at the register's aligned offset and returns the addressed part: the byte or halfword at the lower offset is the more significant one.
- R5: An access wider than the register becomes 2 or 4 native accesses at consecutive native-aligned offsets. The first access carries the most significant part, and read pieces are joined in the same order.
- R6: A write narrower than the register issues a native read followed by a native write to the same offset. The write carries the read value with only the addressed bytes replaced.
- R7: At most one downstream request is outstanding. The request and its address, size, direction and data stay fixed until acknowledged. The upstream ready is a one-cycle pulse that comes only after the final downstream acknowledge.
- R8: A misaligned access (halfword at an odd offset, word at an offset not a multiple of 4, or size code 3) returns an error and issues no downstream access.
- R9: After reset, no downstream request and no upstream ready are asserted.
- R10: An error response, and the response to any write, carries read data of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream request, held until up_ready |
| up_we | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | 0 = byte, 1 = halfword, 2 = word |
| up_addr | input | ADDR_W | Byte address; low 10 bits used |
| up_wdata | input | 32 | Write data, right-justified |
| up_ready | output | 1 | One-cycle completion pulse |
| up_err | output | 1 | Error flag, valid with up_ready |
| up_rdata | output | 32 | Read data, right-justified, valid with up_ready |
| dn_req | output | 1 | Downstream request |
| dn_we | output | 1 | Downstream write |
| dn_size | output | 2 | Downstream size, always the native width |
| dn_addr | output | 10 | Downstream offset |
| dn_wdata | output | 32 | Downstream write data, right-justified |
| dn_ack | input | 1 | Downstream completion pulse |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ack |

## Verification
On every cycle the assertions check the downstream handshake. They check that a pending request holds its fields, that the request and the upstream ready never overlap, and that ready is a single pulse. They also check that no request leaves with an out-of-range offset or a misaligned native size, and that error responses carry zero data. Only the bench scenarios can show the data path: piece ordering and joining, extraction of the narrow part, the read-then-write merge, and the fact that illegal accesses reach nothing downstream. They do this by comparing the logged downstream traffic and the returned data with values derived from the map and the contents of a model register space.

// File: rtl/mwa_pkg.sv
package mwa_pkg;
  localparam int OFS_W  = 10;
  localparam int GROUPS = 128;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_BUSY = 2'd1, S_RESP = 2'd2} mwa_state_t;

  // Map code per 4-byte group: 0 unmapped, 1 byte, 2 half, 3 word
  function automatic logic [1:0] default_code(input int g);
    case (g / 16)
      0:       return 2'd1;
      1:       return 2'd2;
      2:       return 2'd3;
      3:       return 2'd0;
      default: return 2'd1;
    endcase
  endfunction

  function automatic logic [2*GROUPS-1:0] default_map();
    logic [2*GROUPS-1:0] m;
    m = '0;
    for (int g = 0; g < GROUPS; g++) m[2*g +: 2] = default_code(g);
    return m;
  endfunction

  // Data mask for a size code
  function automatic logic [31:0] mask_of(input logic [1:0] s);
    case (s)
      2'd0:    return 32'h0000_00ff;
      2'd1:    return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  // Shift left by one piece of the given size
  function automatic logic [31:0] shl_piece(input logic [31:0] v, input logic [1:0] s);
    case (s)
      2'd0:    return {v[23:0], 8'h00};
      2'd1:    return {v[15:0], 16'h0000};
      default: return 32'h0;
    endcase
  endfunction

  // Top piece of a left-justified register, right-justified
  function automatic logic [31:0] top_piece(input logic [31:0] v, input logic [1:0] s);
    case (s)
      2'd0:    return {24'h0, v[31:24]};
      2'd1:    return {16'h0, v[31:16]};
      default: return v;
    endcase
  endfunction
endpackage

// File: rtl/mwa_width_lut.sv
module mwa_width_lut #(
  parameter int GROUPS = 128,
  parameter logic [2*GROUPS-1:0] MAP = '0,
  localparam int GW = $clog2(GROUPS)
) (
  input  logic [GW-1:0] grp,
  output logic [1:0]    code
);
  logic [1:0] tbl [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_tbl
    assign tbl[g] = MAP[2*g +: 2];
  end

  assign code = tbl[grp];
endmodule

// File: rtl/mwa_plan.sv
module mwa_plan
  import mwa_pkg::*;
#(
  parameter int OW = 10
) (
  input  logic [OW-1:0] ofs,
  input  logic [1:0]    size,
  input  logic          we,
  input  logic [31:0]   wdata,
  input  logic [1:0]    code,
  output logic          err,
  output logic [1:0]    nat_sz,
  output logic [OW-1:0] start,
  output logic [2:0]    pieces,
  output logic          narrow,
  output logic [4:0]    shift,
  output logic [31:0]   shreg_init
);
  logic [OW-1:0] amask;
  logic [1:0]    off;
  logic [2:0]    sh_bytes;
  logic          mis;

  always_comb begin
    case (code)
      2'd3:    nat_sz = 2'd2;
      2'd2:    nat_sz = 2'd1;
      default: nat_sz = 2'd0;
    endcase
    case (nat_sz)
      2'd2:    amask = OW'(3);
      2'd1:    amask = OW'(1);
      default: amask = '0;
    endcase
    mis = (size == 2'd3) || (size == 2'd1 && ofs[0]) || (size == 2'd2 && ofs[1:0] != 2'b00);
    err = ofs[OW-1] || (code == 2'd0) || mis;
    narrow = (size < nat_sz);
    pieces = narrow ? 3'd1 : (3'd1 << (size - nat_sz));
    start = narrow ? (ofs & ~amask) : ofs;
    off = ofs[1:0] & amask[1:0];
    sh_bytes = narrow ? ((3'd1 << nat_sz) - (3'd1 << size) - {1'b0, off}) : 3'd0;
    shift = {sh_bytes[1:0], 3'b000};
    if (!we) shreg_init = '0;
    else begin
      case (size)
        2'd0:    shreg_init = {wdata[7:0], 24'h0};
        2'd1:    shreg_init = {wdata[15:0], 16'h0};
        default: shreg_init = wdata;
      endcase
    end
  end
endmodule

// File: rtl/mwa_seq.sv
module mwa_seq
  import mwa_pkg::*;
#(
  parameter int OW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up_valid,
  input  logic          up_we,
  input  logic [1:0]    up_size,
  input  logic [31:0]   up_wdata,
  input  logic          p_err,
  input  logic [1:0]    p_nat,
  input  logic [OW-1:0] p_start,
  input  logic [2:0]    p_pieces,
  input  logic          p_narrow,
  input  logic [4:0]    p_shift,
  input  logic [31:0]   p_shreg,
  output logic          up_ready,
  output logic          up_err,
  output logic [31:0]   up_rdata,
  output logic          dn_req,
  output logic          dn_we,
  output logic [1:0]    dn_size,
  output logic [OW-1:0] dn_addr,
  output logic [31:0]   dn_wdata,
  input  logic          dn_ack,
  input  logic [31:0]   dn_rdata
);
  mwa_state_t    st;
  logic [OW-1:0] cur;
  logic [1:0]    nsz, szq;
  logic          we_q, narrow_q, wrph;
  logic [2:0]    left;
  logic [31:0]   shreg, acc, wd_q;
  logic [4:0]    sh;
  logic [31:0]   acc_n, extract, merged;
  logic [OW-1:0] next_addr;

  always_comb begin
    acc_n     = shl_piece(acc, nsz) | (dn_rdata & mask_of(nsz));
    extract   = (dn_rdata >> sh) & mask_of(szq);
    merged    = (dn_rdata & ~(mask_of(szq) << sh)) | (wd_q << sh);
    next_addr = cur + OW'(3'd1 << nsz);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      cur <= '0; nsz <= '0; szq <= '0;
      we_q <= 1'b0; narrow_q <= 1'b0; wrph <= 1'b0;
      left <= '0; shreg <= '0; acc <= '0; wd_q <= '0; sh <= '0;
      up_ready <= 1'b0; up_err <= 1'b0; up_rdata <= '0;
      dn_req <= 1'b0; dn_we <= 1'b0; dn_size <= '0; dn_addr <= '0; dn_wdata <= '0;
    end else begin
      up_ready <= 1'b0;
      case (st)
        S_IDLE: if (up_valid) begin
          szq <= up_size; nsz <= p_nat; narrow_q <= p_narrow; we_q <= up_we;
          sh <= p_shift; wd_q <= up_wdata & mask_of(up_size);
          acc <= '0; wrph <= 1'b0; left <= p_pieces; cur <= p_start;
          if (p_err) begin
            st <= S_RESP; up_ready <= 1'b1; up_err <= 1'b1; up_rdata <= '0;
          end else begin
            st <= S_BUSY; up_err <= 1'b0;
            dn_req <= 1'b1; dn_addr <= p_start; dn_size <= p_nat;
            dn_we <= up_we && !p_narrow;
            dn_wdata <= p_narrow ? 32'h0 : top_piece(p_shreg, p_nat);
            shreg <= shl_piece(p_shreg, p_nat);
          end
        end
        S_BUSY: if (dn_ack) begin
          if (narrow_q) begin
            if (we_q && !wrph) begin
              wrph <= 1'b1; dn_we <= 1'b1; dn_wdata <= merged;
            end else begin
              dn_req <= 1'b0; dn_we <= 1'b0; st <= S_RESP; up_ready <= 1'b1;
              up_rdata <= we_q ? 32'h0 : extract;
            end
          end else if (left == 3'd1) begin
            dn_req <= 1'b0; dn_we <= 1'b0; st <= S_RESP; up_ready <= 1'b1;
            up_rdata <= we_q ? 32'h0 : acc_n;
          end else begin
            left <= left - 3'd1; acc <= acc_n;
            cur <= next_addr; dn_addr <= next_addr;
            dn_wdata <= top_piece(shreg, nsz); shreg <= shl_piece(shreg, nsz);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mwa_adapter.sv
module mwa_adapter
  import mwa_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [2*GROUPS-1:0] WIDTH_MAP = mwa_pkg::default_map(),
  localparam int GW = $clog2(GROUPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  input  logic              up_we,
  input  logic [1:0]        up_size,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [31:0]       up_wdata,
  output logic              up_ready,
  output logic              up_err,
  output logic [31:0]       up_rdata,
  output logic              dn_req,
  output logic              dn_we,
  output logic [1:0]        dn_size,
  output logic [OFS_W-1:0]  dn_addr,
  output logic [31:0]       dn_wdata,
  input  logic              dn_ack,
  input  logic [31:0]       dn_rdata
);
  logic [OFS_W-1:0] ofs;
  logic [1:0]       code, p_nat;
  logic             p_err, p_narrow;
  logic [OFS_W-1:0] p_start;
  logic [2:0]       p_pieces;
  logic [4:0]       p_shift;
  logic [31:0]      p_shreg;

  assign ofs = up_addr[OFS_W-1:0];

  mwa_width_lut #(.GROUPS(GROUPS), .MAP(WIDTH_MAP)) u_lut (
    .grp(ofs[GW+1:2]), .code(code)
  );

  mwa_plan #(.OW(OFS_W)) u_plan (
    .ofs(ofs), .size(up_size), .we(up_we), .wdata(up_wdata), .code(code),
    .err(p_err), .nat_sz(p_nat), .start(p_start), .pieces(p_pieces),
    .narrow(p_narrow), .shift(p_shift), .shreg_init(p_shreg)
  );

  mwa_seq #(.OW(OFS_W)) u_seq (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_we(up_we), .up_size(up_size),
    .up_wdata(up_wdata), .p_err(p_err), .p_nat(p_nat), .p_start(p_start),
    .p_pieces(p_pieces), .p_narrow(p_narrow), .p_shift(p_shift), .p_shreg(p_shreg),
    .up_ready(up_ready), .up_err(up_err), .up_rdata(up_rdata),
    .dn_req(dn_req), .dn_we(dn_we), .dn_size(dn_size), .dn_addr(dn_addr),
    .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_rdata(dn_rdata)
  );
endmodule

// File: rtl/mwa_adapter_chk.sv
module mwa_adapter_chk (
  input logic        clk,
  input logic        rst,
  input logic        up_ready,
  input logic        up_err,
  input logic [31:0] up_rdata,
  input logic        dn_req,
  input logic        dn_we,
  input logic [1:0]  dn_size,
  input logic [9:0]  dn_addr,
  input logic [31:0] dn_wdata,
  input logic        dn_ack
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    dn_req && !dn_ack |=> dn_req && $stable(dn_addr) && $stable(dn_we)
                          && $stable(dn_size) && $stable(dn_wdata));

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
    !(dn_req && up_ready));

  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    up_ready |=> !up_ready);

  assert_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> !dn_addr[9]);

  assert_native_aligned_R5: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> (dn_size != 2'd3) && !(dn_size == 2'd1 && dn_addr[0])
               && !(dn_size == 2'd2 && dn_addr[1:0] != 2'b00));

  assert_err_zero_R10: assert property (@(posedge clk) disable iff (rst)
    up_ready && up_err |-> up_rdata == 32'h0);
endmodule

bind mwa_adapter mwa_adapter_chk u_chk (
  .clk(clk), .rst(rst), .up_ready(up_ready), .up_err(up_err), .up_rdata(up_rdata),
  .dn_req(dn_req), .dn_we(dn_we), .dn_size(dn_size), .dn_addr(dn_addr),
  .dn_wdata(dn_wdata), .dn_ack(dn_ack)
);

// File: tb/sim_mwa_adapter.sv
`timescale 1ns/1ps
module sim_mwa_adapter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_valid = 1'b0, up_we = 1'b0;
  logic [1:0] up_size = 2'd0;
  logic [15:0] up_addr = '0;
  logic [31:0] up_wdata = '0;
  logic up_ready, up_err;
  logic [31:0] up_rdata;
  logic dn_req, dn_we, dn_ack;
  logic [1:0] dn_size;
  logic [9:0] dn_addr;
  logic [31:0] dn_wdata, dn_rdata;

  int n_run = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  mwa_adapter u0 (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_we(up_we), .up_size(up_size),
    .up_addr(up_addr), .up_wdata(up_wdata), .up_ready(up_ready), .up_err(up_err),
    .up_rdata(up_rdata), .dn_req(dn_req), .dn_we(dn_we), .dn_size(dn_size),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_rdata(dn_rdata)
  );

  // Downstream register space model: big-endian bytes, one wait cycle
  logic [7:0] mem [0:511];
  logic [9:0] lg_addr [0:63];
  logic [1:0] lg_size [0:63];
  logic       lg_we   [0:63];
  logic [31:0] lg_wd  [0:63];
  int n_log = 0;
  logic wt;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      dn_ack <= 1'b0; dn_rdata <= '0; wt <= 1'b0;
      for (int i = 0; i < 512; i++) mem[i] <= 8'(i) ^ 8'h5a;
    end else begin
      dn_ack <= 1'b0;
      if (dn_req && !dn_ack) begin
        if (!wt) wt <= 1'b1;
        else begin
          int nb;
          logic [31:0] v;
          wt <= 1'b0;
          dn_ack <= 1'b1;
          nb = 1 << dn_size;
          lg_addr[n_log % 64] <= dn_addr; lg_size[n_log % 64] <= dn_size;
          lg_we[n_log % 64] <= dn_we; lg_wd[n_log % 64] <= dn_wdata;
          n_log <= n_log + 1;
          v = '0;
          for (int k = 0; k < nb; k++) begin
            v = {v[23:0], mem[dn_addr[8:0] + 9'(k)]};
            if (dn_we) mem[dn_addr[8:0] + 9'(k)] <= 8'(dn_wdata >> (8 * (nb - 1 - k)));
          end
          dn_rdata <= dn_we ? 32'h0 : v;
        end
      end
    end
  end

  function automatic logic [7:0] init_b(input int a);
    return 8'(a) ^ 8'h5a;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic [1:0] s, input logic w,
                        input logic [31:0] wd, output logic [31:0] rd, output logic e,
                        output int first, output int cnt);
    int guard;
    first = n_log;
    @(negedge clk);
    up_valid = 1'b1; up_we = w; up_size = s; up_addr = a; up_wdata = wd;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!up_ready && guard < 200);
    if (!up_ready) chk(0, "R7 no response", 32'h0, 32'h1);
    else chk(!dn_req, "R7 request still high at ready", 32'(dn_req), 32'h0);
    rd = up_rdata; e = up_err; cnt = n_log - first;
    up_valid = 1'b0; up_we = 1'b0; up_wdata = '0;
  endtask

  task automatic chk_log(input int idx, input logic [9:0] a, input logic [1:0] s,
                         input logic w, input logic [31:0] wd, input string tag);
    chk(lg_addr[idx % 64] == a, {tag, " addr"}, 32'(lg_addr[idx % 64]), 32'(a));
    chk(lg_size[idx % 64] == s && lg_we[idx % 64] == w, {tag, " size/dir"},
        {29'h0, lg_we[idx % 64], lg_size[idx % 64]}, {29'h0, w, s});
    if (w) chk(lg_wd[idx % 64] == wd, {tag, " wdata"}, lg_wd[idx % 64], wd);
  endtask

  task automatic t_reset();
    chk(!up_ready && !dn_req, "R9 reset outputs", {30'h0, up_ready, dn_req}, 32'h0);
  endtask

  task automatic t_same_width();
    logic [31:0] rd; logic e; int f, c;
    access(16'h0005, 2'd0, 1'b0, 0, rd, e, f, c);
    chk(!e && rd == {24'h0, init_b(5)}, "R3 byte read", rd, {24'h0, init_b(5)});
    chk(c == 1, "R3 access count", 32'(c), 32'd1);
    chk_log(f, 10'h005, 2'd0, 1'b0, 0, "R3");
  endtask

  task automatic t_narrow_read();
    logic [31:0] rd; logic e; int f, c;
    access(16'h0042, 2'd0, 1'b0, 0, rd, e, f, c);
    chk(rd == 32'(init_b(8'h42)), "R4 even byte from half", rd, 32'(init_b(8'h42)));
    chk_log(f, 10'h042, 2'd1, 1'b0, 0, "R4 half fetch");
    access(16'h0043, 2'd0, 1'b0, 0, rd, e, f, c);
    chk(rd == 32'(init_b(8'h43)), "R4 odd byte from half", rd, 32'(init_b(8'h43)));
    access(16'h0082, 2'd1, 1'b0, 0, rd, e, f, c);
    chk(rd == {16'h0, init_b(8'h82), init_b(8'h83)}, "R4 low half of word", rd,
        {16'h0, init_b(8'h82), init_b(8'h83)});
    chk(c == 1, "R4 single fetch", 32'(c), 32'd1);
    chk_log(f, 10'h080, 2'd2, 1'b0, 0, "R4 word fetch");
    access(16'h0080, 2'd1, 1'b0, 0, rd, e, f, c);
    chk(rd == {16'h0, init_b(8'h80), init_b(8'h81)}, "R4 high half of word", rd,
        {16'h0, init_b(8'h80), init_b(8'h81)});
    access(16'h0081, 2'd0, 1'b0, 0, rd, e, f, c);
    chk(rd == 32'(init_b(8'h81)), "R4 byte from word", rd, 32'(init_b(8'h81)));
  endtask

  task automatic t_split();
    logic [31:0] rd, ex; logic e; int f, c;
    access(16'h0010, 2'd1, 1'b0, 0, rd, e, f, c);
    ex = {16'h0, init_b(8'h10), init_b(8'h11)};
    chk(rd == ex && c == 2, "R5 half over bytes", rd, ex);
    chk_log(f, 10'h010, 2'd0, 1'b0, 0, "R5 first byte");
    chk_log(f + 1, 10'h011, 2'd0, 1'b0, 0, "R5 second byte");
    access(16'h0020, 2'd2, 1'b0, 0, rd, e, f, c);
    ex = {init_b(8'h20), init_b(8'h21), init_b(8'h22), init_b(8'h23)};
    chk(rd == ex && c == 4, "R5 word over bytes", rd, ex);
    chk_log(f + 3, 10'h023, 2'd0, 1'b0, 0, "R5 last byte");
    access(16'h0044, 2'd2, 1'b0, 0, rd, e, f, c);
    ex = {init_b(8'h44), init_b(8'h45), init_b(8'h46), init_b(8'h47)};
    chk(rd == ex && c == 2, "R5 word over halves", rd, ex);
    chk_log(f + 1, 10'h046, 2'd1, 1'b0, 0, "R5 second half");
    access(16'h0030, 2'd2, 1'b1, 32'h1122_3344, rd, e, f, c);
    chk(c == 4 && rd == 0, "R5 R10 split write", rd, 32'h0);
    chk_log(f, 10'h030, 2'd0, 1'b1, 32'h11, "R5 write piece 0");
    chk_log(f + 3, 10'h033, 2'd0, 1'b1, 32'h44, "R5 write piece 3");
    access(16'h0030, 2'd2, 1'b0, 0, rd, e, f, c);
    chk(rd == 32'h1122_3344, "R5 word readback", rd, 32'h1122_3344);
  endtask

  task automatic t_rmw();
    logic [31:0] rd, ex; logic e; int f, c;
    access(16'h0049, 2'd0, 1'b1, 32'h0000_00a5, rd, e, f, c);
    ex = {16'h0, init_b(8'h48), 8'ha5};
    chk(c == 2, "R6 byte rmw count", 32'(c), 32'd2);
    chk_log(f, 10'h048, 2'd1, 1'b0, 0, "R6 read phase");
    chk_log(f + 1, 10'h048, 2'd1, 1'b1, ex, "R6 write phase");
    access(16'h008c, 2'd1, 1'b1, 32'h0000_beef, rd, e, f, c);
    ex = {16'hbeef, init_b(8'h8e), init_b(8'h8f)};
    chk_log(f + 1, 10'h08c, 2'd2, 1'b1, ex, "R6 half into word");
    access(16'h008e, 2'd0, 1'b1, 32'h0000_0077, rd, e, f, c);
    access(16'h008c, 2'd2, 1'b0, 0, rd, e, f, c);
    ex = {16'hbeef, 8'h77, init_b(8'h8f)};
    chk(rd == ex, "R6 word readback after merges", rd, ex);
  endtask

  task automatic t_errors();
    logic [31:0] rd; logic e; int f, c;
    access(16'h0200, 2'd0, 1'b0, 0, rd, e, f, c);
    chk(e && c == 0 && rd == 0, "R1 R10 offset 0x200 error", {rd[30:0], e}, 32'h1);
    access(16'h4005, 2'd0, 1'b0, 0, rd, e, f, c);
    chk(!e && rd == 32'(init_b(5)), "R1 high address bits ignored", rd, 32'(init_b(5)));
    access(16'h00c0, 2'd2, 1'b1, 32'hdead_beef, rd, e, f, c);
    chk(e && c == 0, "R2 unmapped group error", 32'(c), 32'h0);
    access(16'h0011, 2'd1, 1'b0, 0, rd, e, f, c);
    chk(e && c == 0 && rd == 0, "R8 odd halfword error", {rd[30:0], e}, 32'h1);
    access(16'h0082, 2'd2, 1'b0, 0, rd, e, f, c);
    chk(e && c == 0, "R8 misaligned word error", 32'(c), 32'h0);
    access(16'h0004, 2'd3, 1'b0, 0, rd, e, f, c);
    chk(e && c == 0, "R8 size code 3 error", 32'(c), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_same_width();
    t_narrow_read();
    t_split();
    t_rmw();
    t_errors();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 50000);
    chk(0, "watchdog expired", 32'(cyc), 32'h0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule